// File: doc/BRIEF.md
# Two-Channel Converter Data and Trigger Front End

This block is the digital side of a two-channel 12-bit digital-to-analog converter. Software writes each channel's next code through a small register port. Three alignment views are offered per channel: 12-bit right-aligned, 12-bit left-aligned and 8-bit right-aligned. A packed view loads both channels with one write. Every view lands in one 12-bit holding value per channel. The holding value reaches the channel's output code either one cycle after the write, or when a chosen trigger arrives. The output code drives the analog converter, which yields reference × code / 4095.

The trigger for each channel is one of six single-cycle hardware event inputs or a per-channel software bit. A hardware trigger can raise a DMA request. The request is held until a one-cycle acknowledge arrives. If a second hardware trigger arrives while the request is still pending, an underrun flag is set. That flag is cleared by writing one to it, and it raises a channel interrupt when the interrupt is enabled.

Top module: `dacfe_top`

## Requirements
- R1: After reset, both output codes, both holding values, the control, software trigger and status registers, `dma_req` and `irq` are all zero.
- R2: For channel 0, a write to offset 0x08 loads bits [11:0] into the holding value. A write to 0x0C loads bits [15:4]. A write to 0x10 loads bits [7:0] shifted left by four. Channel 1 uses the same three views at 0x14, 0x18 and 0x1C. Reading 0x08 or 0x14 returns that channel's holding value.
- R3: The packed view updates both channels from one write. At 0x20 (12-bit right), channel 0 takes [11:0] and channel 1 takes [27:16]. At 0x24 (12-bit left), channel 0 takes [15:4] and channel 1 takes [31:20]. At 0x28 (8-bit), channel 0 takes [7:0] and channel 1 takes [15:8], each shifted left by four.
- R4: With the enable bit (control bit 0) set and the trigger-enable bit (bit 1) clear, the output code takes the holding value one cycle after the write. A disabled channel never changes its output code.
- R5: With trigger-enable set, the output code changes only on the cycle after the selected source fires. Select field bits [4:2] pick the source: codes 0 to 5 are the hardware inputs `hw_trig[0..5]` and code 6 is the software bit. Pulses on unselected sources have no effect.
- R6: Register 0x04 bit 0 and bit 1 are the software triggers of channel 0 and channel 1. Writing both at once triggers both channels. Each bit reads as one for one cycle and then clears itself.
- R7: While a channel's enable bit is set, control writes leave its trigger-enable bit and select field unchanged. The enable bit, DMA enable bit and interrupt enable bit remain writable.
- R8: When DMA enable (control bit 5) is set, a selected hardware trigger raises that channel's `dma_req`. A software trigger never raises it. The request stays high until `dma_ack` is seen.
- R9: A selected hardware trigger that arrives while `dma_req` is high and unacknowledged sets the channel's underrun flag. The flag is status register 0x34 bit 0 for channel 0. Writing one to the flag bit clears it, and writing zero leaves it unchanged.
- R10: `irq[c]` is high exactly when the channel's underrun flag and its interrupt enable (control bit 6) are both set.
- R11: Channel 1's control fields and status flag use channel 0's layout shifted up by 16 bits. The output codes read back at 0x2C (channel 0) and 0x30 (channel 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 8 | Write byte offset |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 8 | Read byte offset |
| reg_rdata | output | 32 | Read data, combinational from `reg_raddr` |
| hw_trig | input | 6 | Single-cycle hardware trigger pulses, shared by both channels |
| dma_ack | input | 2 | One-cycle DMA acknowledge per channel |
| dma_req | output | 2 | DMA request per channel, held until acknowledged |
| irq | output | 2 | Underrun interrupt per channel |
| dac_code | output | 24 | Output codes: channel 0 in [11:0], channel 1 in [23:12] |

## Verification
The timing is fixed. A write is visible in the holding value in the cycle right after the write edge. An untriggered transfer reaches the output code one cycle later. Output code, `dma_req`, the underrun flag and `irq` all follow the clock edge that samples the trigger pulse. A software bit reads as one for exactly one cycle, and its transfer lands on the next edge. The driver advances time edge by edge. After each edge it queues the values due in that cycle, and the monitor compares them at the following falling edge. Each check therefore lands on the first cycle in which the result is due, and no check waits for a result to settle.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int REG_AW    = 8;
  localparam int SEL_W     = 3;
  localparam int CH_STRIDE = 16;

  localparam logic [REG_AW-1:0] A_CTRL     = 8'h00;
  localparam logic [REG_AW-1:0] A_SWTRIG   = 8'h04;
  localparam logic [REG_AW-1:0] A_CH0_BASE = 8'h08;
  localparam logic [REG_AW-1:0] A_CH1_BASE = 8'h14;
  localparam logic [REG_AW-1:0] A_DUAL     = 8'h20;
  localparam logic [REG_AW-1:0] A_CODE0    = 8'h2C;
  localparam logic [REG_AW-1:0] A_CODE1    = 8'h30;
  localparam logic [REG_AW-1:0] A_STAT     = 8'h34;

  // view offsets above each 12-bit right-aligned base
  localparam logic [REG_AW-1:0] STEP_L12 = 8'h04;
  localparam logic [REG_AW-1:0] STEP_R8  = 8'h08;

  typedef enum logic [1:0] {FMT_R12, FMT_L12, FMT_R8, FMT_NONE} fmt_e;

  // bit 0 en, bit 1 trig_en, [4:2] sel, bit 5 dma_en, bit 6 udr_ie
  typedef struct packed {
    logic             udr_ie;
    logic             dma_en;
    logic [SEL_W-1:0] sel;
    logic             trig_en;
    logic             en;
  } chan_cfg_t;

  localparam int CFG_W = $bits(chan_cfg_t);
endpackage

// File: rtl/dacfe_wdec.sv
module dacfe_wdec
  import dacfe_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              wr,
  input  logic [REG_AW-1:0] waddr,
  input  logic [31:0]       wdata,
  output logic [1:0]        load,
  output logic [CODE_W-1:0] val0,
  output logic [CODE_W-1:0] val1
);
  localparam int PAD_W = CODE_W - 8;

  function automatic fmt_e view_of(logic [REG_AW-1:0] a, logic [REG_AW-1:0] base);
    if (a == base)                 return FMT_R12;
    else if (a == base + STEP_L12) return FMT_L12;
    else if (a == base + STEP_R8)  return FMT_R8;
    else                           return FMT_NONE;
  endfunction

  function automatic logic [CODE_W-1:0] align(fmt_e f, logic [15:0] w);
    case (f)
      FMT_R12: return w[CODE_W-1:0];
      FMT_L12: return w[15 -: CODE_W];
      FMT_R8:  return {w[7:0], {PAD_W{1'b0}}};
      default: return '0;
    endcase
  endfunction

  fmt_e        f0, f1, fd;
  logic [15:0] lo_half, hi_half;

  always_comb begin
    f0 = view_of(waddr, A_CH0_BASE);
    f1 = view_of(waddr, A_CH1_BASE);
    fd = view_of(waddr, A_DUAL);
    load[0] = wr & ((f0 != FMT_NONE) | (fd != FMT_NONE));
    load[1] = wr & ((f1 != FMT_NONE) | (fd != FMT_NONE));
    if (fd == FMT_R8) begin
      lo_half = {8'h00, wdata[7:0]};
      hi_half = {8'h00, wdata[15:8]};
    end else begin
      lo_half = wdata[15:0];
      hi_half = wdata[31:16];
    end
    if (fd != FMT_NONE) begin
      val0 = align(fd, lo_half);
      val1 = align(fd, hi_half);
    end else begin
      val0 = align(f0, wdata[15:0]);
      val1 = align(f1, wdata[15:0]);
    end
  end
endmodule

// File: rtl/dacfe_chan.sv
module dacfe_chan
  import dacfe_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int NUM_HW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  chan_cfg_t         cfg,
  input  logic [NUM_HW-1:0] hw_trig,
  input  logic              sw_trig,
  input  logic              load,
  input  logic [CODE_W-1:0] load_val,
  input  logic              dma_ack,
  input  logic              udr_clr,
  output logic [CODE_W-1:0] hold,
  output logic [CODE_W-1:0] code,
  output logic              dma_req,
  output logic              udr
);
  localparam logic [SEL_W-1:0] SW_SEL = SEL_W'(NUM_HW);

  logic pend_q;
  logic hw_hit, sw_hit, xfer, dma_fire;

  always_comb begin
    hw_hit = 1'b0;
    for (int i = 0; i < NUM_HW; i++) begin
      if (cfg.sel == SEL_W'(i) && hw_trig[i]) hw_hit = 1'b1;
    end
    hw_hit   = hw_hit & cfg.en & cfg.trig_en;
    sw_hit   = cfg.en & cfg.trig_en & (cfg.sel == SW_SEL) & sw_trig;
    xfer     = cfg.en & ((~cfg.trig_en & pend_q) | hw_hit | sw_hit);
    dma_fire = hw_hit & cfg.dma_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold   <= '0;
      pend_q <= 1'b0;
      code   <= '0;
    end else begin
      if (load) hold <= load_val;
      pend_q <= load & cfg.en & ~cfg.trig_en;
      if (xfer) code <= hold;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_req <= 1'b0;
      udr     <= 1'b0;
    end else begin
      if (dma_fire) dma_req <= 1'b1;
      else if (dma_ack) dma_req <= 1'b0;
      if (dma_fire && dma_req && !dma_ack) udr <= 1'b1;
      else if (udr_clr) udr <= 1'b0;
    end
  end

  assert_req_from_hw_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req) |-> $past(|hw_trig));
  assert_ack_drops_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && dma_ack && !dma_fire |=> !dma_req);
  assert_udr_needs_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(udr) |-> $past(dma_req));
  assert_code_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code) |-> $past(cfg.en));
endmodule

// File: rtl/dacfe_top.sv
module dacfe_top
  import dacfe_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int NUM_HW = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [REG_AW-1:0]   reg_waddr,
  input  logic [31:0]         reg_wdata,
  input  logic [REG_AW-1:0]   reg_raddr,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_HW-1:0]   hw_trig,
  input  logic [1:0]          dma_ack,
  output logic [1:0]          dma_req,
  output logic [1:0]          irq,
  output logic [2*CODE_W-1:0] dac_code
);
  localparam int NCH = 2;

  chan_cfg_t         cfg_q [NCH];
  logic [NCH-1:0]    sw_q;
  logic [NCH-1:0]    load_w, udr_w, udr_clr;
  logic [CODE_W-1:0] ld_val [NCH];
  logic [CODE_W-1:0] hold_w [NCH];
  logic [CODE_W-1:0] code_w [NCH];
  logic              ctrl_wr, sw_wr, stat_wr;

  assign ctrl_wr = reg_wr && (reg_waddr == A_CTRL);
  assign sw_wr   = reg_wr && (reg_waddr == A_SWTRIG);
  assign stat_wr = reg_wr && (reg_waddr == A_STAT);

  dacfe_wdec #(.CODE_W(CODE_W)) u_wdec (
    .wr    (reg_wr),
    .waddr (reg_waddr),
    .wdata (reg_wdata),
    .load  (load_w),
    .val0  (ld_val[0]),
    .val1  (ld_val[1])
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) cfg_q[c] <= '0;
      sw_q <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (ctrl_wr) begin
          chan_cfg_t nx;
          nx = chan_cfg_t'(reg_wdata[c*CH_STRIDE +: CFG_W]);
          cfg_q[c].en     <= nx.en;
          cfg_q[c].dma_en <= nx.dma_en;
          cfg_q[c].udr_ie <= nx.udr_ie;
          if (!cfg_q[c].en) begin
            cfg_q[c].trig_en <= nx.trig_en;
            cfg_q[c].sel     <= nx.sel;
          end
        end
      end
      // software bits live for exactly one cycle
      sw_q <= sw_wr ? reg_wdata[NCH-1:0] : '0;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign udr_clr[c] = stat_wr & reg_wdata[c*CH_STRIDE];

    dacfe_chan #(.CODE_W(CODE_W), .NUM_HW(NUM_HW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg      (cfg_q[c]),
      .hw_trig  (hw_trig),
      .sw_trig  (sw_q[c]),
      .load     (load_w[c]),
      .load_val (ld_val[c]),
      .dma_ack  (dma_ack[c]),
      .udr_clr  (udr_clr[c]),
      .hold     (hold_w[c]),
      .code     (code_w[c]),
      .dma_req  (dma_req[c]),
      .udr      (udr_w[c])
    );

    assign irq[c] = udr_w[c] & cfg_q[c].udr_ie;
    assign dac_code[c*CODE_W +: CODE_W] = code_w[c];

    assert_sel_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_q[c].en) |-> ($stable(cfg_q[c].sel) && $stable(cfg_q[c].trig_en)));
    assert_sw_self_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sw_q[c] && !(sw_wr && reg_wdata[c]) |=> !sw_q[c]);
    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[c]) |-> (udr_w[c] && cfg_q[c].udr_ie));
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_raddr == A_CTRL) begin
      for (int c = 0; c < NCH; c++) reg_rdata[c*CH_STRIDE +: CFG_W] = cfg_q[c];
    end else if (reg_raddr == A_SWTRIG) begin
      reg_rdata[NCH-1:0] = sw_q;
    end else if (reg_raddr == A_CH0_BASE) begin
      reg_rdata[CODE_W-1:0] = hold_w[0];
    end else if (reg_raddr == A_CH1_BASE) begin
      reg_rdata[CODE_W-1:0] = hold_w[1];
    end else if (reg_raddr == A_CODE0) begin
      reg_rdata[CODE_W-1:0] = code_w[0];
    end else if (reg_raddr == A_CODE1) begin
      reg_rdata[CODE_W-1:0] = code_w[1];
    end else if (reg_raddr == A_STAT) begin
      for (int c = 0; c < NCH; c++) reg_rdata[c*CH_STRIDE] = udr_w[c];
    end
  end
endmodule

// File: tb/test_dacfe_top.sv
module test_dacfe_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW  = 12;
  localparam int NHW = 6;
  localparam int K_C0 = 0, K_C1 = 1, K_REQ = 2, K_IRQ = 3, K_RD = 4;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [7:0]    reg_waddr = '0, reg_raddr = '0;
  logic [31:0]   reg_wdata = '0, reg_rdata;
  logic [NHW-1:0] hw_trig = '0;
  logic [1:0]    dma_ack = '0, dma_req, irq;
  logic [2*CW-1:0] dac_code;

  dacfe_top #(.CODE_W(CW), .NUM_HW(NHW)) i_dacfe_top (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .hw_trig(hw_trig), .dma_ack(dma_ack), .dma_req(dma_req), .irq(irq),
    .dac_code(dac_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t sbq[$];
  int total = 0, bad = 0;
  bit done = 1'b0;

  // monitor: compares every queued expectation at the falling edge
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sbq.pop_front();
      case (it.kind)
        K_C0:    act = {20'h0, dac_code[CW-1:0]};
        K_C1:    act = {20'h0, dac_code[2*CW-1:CW]};
        K_REQ:   act = {30'h0, dma_req};
        K_IRQ:   act = {30'h0, irq};
        default: act = reg_rdata;
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask
  task automatic expect_v(int k, logic [31:0] v, string tag);
    item_t it;
    it.kind = k; it.exp = v; it.tag = tag;
    sbq.push_back(it);
  endtask
  task automatic rd(logic [7:0] a, logic [31:0] v, string tag);
    reg_raddr = a;
    expect_v(K_RD, v, tag);
    @(negedge clk); #1;
  endtask
  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask
  task automatic pulse(int i);
    hw_trig[i] = 1'b1; step(); hw_trig = '0;
  endtask
  task automatic ack(int c);
    dma_ack[c] = 1'b1; step(); dma_ack = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    expect_v(K_C0, 0, "R1 code0"); expect_v(K_C1, 0, "R1 code1");
    expect_v(K_REQ, 0, "R1 dma_req"); expect_v(K_IRQ, 0, "R1 irq");
    rd(8'h00, 0, "R1 ctrl");
    rd(8'h34, 0, "R1 status");

    // R4 untriggered, R2 alignment views on channel 0
    wr(8'h00, 32'h0000_0001);
    wr(8'h08, 32'h0000_0ABC);
    rd(8'h08, 32'hABC, "R2 hold readback");
    step(); expect_v(K_C0, 32'hABC, "R4 untriggered transfer");
    wr(8'h0C, 32'h0000_1230); step(); expect_v(K_C0, 32'h123, "R2 left12 view");
    wr(8'h10, 32'h0000_005A); step(); expect_v(K_C0, 32'h5A0, "R2 right8 view");

    // R4 disabled channel 1 ignores data
    wr(8'h14, 32'h0000_0777); step();
    expect_v(K_C1, 0, "R4 disabled no transfer");
    rd(8'h14, 32'h777, "R2 ch1 hold");

    // R3 / R11 packed view
    wr(8'h00, 32'h0001_0001);
    wr(8'h20, 32'h0DEF_0321); step();
    expect_v(K_C0, 32'h321, "R3 dual12R ch0"); expect_v(K_C1, 32'hDEF, "R3 dual12R ch1");
    wr(8'h24, 32'hABC0_1230); step();
    expect_v(K_C0, 32'h123, "R3 dual12L ch0"); expect_v(K_C1, 32'hABC, "R3 dual12L ch1");
    wr(8'h28, 32'h0000_C34B); step();
    expect_v(K_C0, 32'h4B0, "R3 dual8 ch0"); expect_v(K_C1, 32'hC30, "R3 dual8 ch1");
    rd(8'h30, 32'hC30, "R11 code1 readback");

    // R7 trigger select locked while enabled
    wr(8'h00, 32'h0001_000B);
    rd(8'h00, 32'h0001_0001, "R7 sel locked");
    wr(8'h08, 32'h0000_0111); step(); expect_v(K_C0, 32'h111, "R7 still untriggered");

    // configure: ch0 hw source 2 with DMA and irq, ch1 software
    wr(8'h00, 32'h001A_006A);
    wr(8'h00, 32'h001B_006B);
    rd(8'h00, 32'h001B_006B, "R11 ctrl layout");

    // R5 waits for selected source
    wr(8'h08, 32'h0000_0400); step(); expect_v(K_C0, 32'h111, "R5 waits for trigger");
    pulse(1); expect_v(K_C0, 32'h111, "R5 other source ignored"); expect_v(K_REQ, 0, "R8 no req");
    pulse(2); expect_v(K_C0, 32'h400, "R5 selected source"); expect_v(K_REQ, 1, "R8 req raised");

    // R9 underrun, R10 irq
    wr(8'h08, 32'h0000_0500);
    pulse(2);
    expect_v(K_C0, 32'h500, "R5 second trigger"); expect_v(K_REQ, 1, "R8 req held");
    expect_v(K_IRQ, 1, "R10 irq on underrun");
    rd(8'h34, 1, "R9 underrun flag");
    ack(0); expect_v(K_REQ, 0, "R8 ack clears req");

    // R6 software trigger
    wr(8'h14, 32'h0000_09AB); step(); expect_v(K_C1, 32'hC30, "R5 ch1 waits");
    wr(8'h04, 32'h2);
    rd(8'h04, 32'h2, "R6 sw bit set");
    step(); expect_v(K_C1, 32'h9AB, "R6 sw transfer");
    rd(8'h04, 0, "R6 sw bit self-clears");
    wr(8'h00, 32'h003B_006B);
    wr(8'h14, 32'h0000_0222);
    wr(8'h04, 32'h3); step();
    expect_v(K_C1, 32'h222, "R6 dual sw trigger");
    expect_v(K_C0, 32'h500, "R5 sw ignored by hw-selected ch0");
    expect_v(K_REQ, 0, "R8 no req on sw trigger");

    // R9 write-one-to-clear
    rd(8'h34, 1, "R9 flag still set");
    wr(8'h34, 32'h0);
    rd(8'h34, 1, "R9 zero write no effect");
    wr(8'h34, 32'h1);
    rd(8'h34, 0, "R9 w1c clears");
    expect_v(K_IRQ, 0, "R10 irq drops");

    // R10 interrupt masked
    wr(8'h00, 32'h003B_002B);
    pulse(2); pulse(2);
    expect_v(K_IRQ, 0, "R10 masked irq"); expect_v(K_REQ, 1, "R8 req pending");
    rd(8'h34, 1, "R9 flag with irq masked");
    ack(0); expect_v(K_REQ, 0, "R8 final ack");

    step(); step();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule